// File: doc/BRIEF.md
# Scrambled Grayscale PWM Generator

This block turns sixteen grayscale words into sixteen pulse-width modulated enables, one per output channel. Every channel shares one counter chain that runs on the grayscale clock. In the conventional mode a channel is on for the first `value` clocks of each period. In the three scrambled modes the upper part of each value is spread over several short sub-periods, and the lower six bits follow in one closing segment. Refresh flicker drops as a result, and the on-time over a full cycle still equals the grayscale value.

The grayscale depth can be 12 or 16 bits. New words arrive as one wide word with a single-cycle load strobe. In one handover mode the words are parked in a pending bank and take effect only at the start of the next cycle. In the other they take effect on the clock that follows the strobe. An end-of-cycle pulse marks the last clock of every cycle. Depth and mode are static settings and may change only while reset is held.

Top module: `scrambled_gs_pwm`

## Requirements
- R1: While reset is low, and directly after it, every active value is zero. All channel outputs and `cycle_end` are low, and the cycle position is zero.
- R2: With `mode` = 2'b11 (conventional), the period is 2^W clocks: W = 12 when `depth16` = 0 and W = 16 when `depth16` = 1. Channel i is on in cycle positions 0 to v-1. In 12-bit depth, v is the low 12 bits of the word and the upper 4 bits are ignored.
- R3: With `mode` = 2'b00 and 12-bit depth, a cycle is 4160 clocks. It starts with 64 sub-periods of 64 clocks, and in each the channel is on while the step count (0..63) is below v[11:6]. A 64-clock segment follows that is on for its first v[5:0] clocks.
- R4: With `mode` = 2'b01, the step count advances once every 4 clocks and there are 16 sub-periods. The closing 64-clock segment is as in R3.
- R5: With `mode` = 2'b10, the step count advances once every 16 clocks and there are 4 sub-periods. The closing 64-clock segment is as in R3.
- R6: In 16-bit depth with a scrambled mode, the upper part is v[15:6] and the step count runs 0..1023. The sub-period therefore lasts 1024 × prescale clocks, the cycle lasts 65600 clocks, and the on-time per cycle is v.
- R7: A channel whose effective value is zero stays off for the whole cycle.
- R8: `cycle_end` is high for exactly the last clock of each cycle. On the next clock the position is back at zero.
- R9: With `sync_at_end` = 1, a loaded word is held back and first drives the outputs at position zero of the next cycle. A further load before that replaces it.
- R10: With `sync_at_end` = 0, a loaded word drives the outputs from the clock after the strobe, and the cycle position is not disturbed.
- R11: Bits [16i+15:16i] of `gs_data` drive `pwm_out[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Grayscale clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| depth16 | input | 1 | 1 selects 16-bit values, 0 selects 12-bit values |
| mode | input | 2 | 00/01/10 scrambled with prescale 1/4/16, 11 conventional |
| sync_at_end | input | 1 | 1 defers new words to the next cycle start, 0 applies them at once |
| gs_load | input | 1 | One-clock strobe that takes in `gs_data` |
| gs_data | input | 256 | Sixteen 16-bit grayscale words, channel 0 in the low bits |
| pwm_out | output | 16 | Channel on/off enables |
| cycle_end | output | 1 | High on the last clock of each cycle |

## Verification
The hardest case to reach is a change of data that lands on or near a cycle boundary in deferred mode, because the boundary falls only once in thousands of clocks. The stimulus fires loads at random clocks over several consecutive cycles in each mode. A bench model is then compared with every output on every clock, so boundary-adjacent loads and the replacement of pending words are both covered. The 16-bit scrambled cycle is run end to end once, which exercises the sub-period rollover into the closing segment at its largest count.

// File: rtl/scrambled_gs_pwm.sv
`timescale 1ns/1ps
module scrambled_gs_pwm #(
  parameter int NCH  = 16,
  parameter int GSW  = 16,
  parameter int NARW = 12,
  parameter int LSBW = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               depth16,
  input  logic [1:0]         mode,
  input  logic               sync_at_end,
  input  logic               gs_load,
  input  logic [NCH*GSW-1:0] gs_data,
  output logic [NCH-1:0]     pwm_out,
  output logic               cycle_end
);
  localparam int PREW = 4;
  localparam logic [GSW-1:0] FULL_W  = {GSW{1'b1}};
  localparam logic [GSW-1:0] FULL_N  = GSW'((64'd1 << NARW) - 64'd1);
  localparam logic [GSW-1:0] FULL_L  = GSW'((64'd1 << LSBW) - 64'd1);
  localparam logic [GSW-1:0] FULL_MW = GSW'((64'd1 << (GSW - LSBW)) - 64'd1);
  localparam logic [GSW-1:0] FULL_MN = GSW'((64'd1 << (NARW - LSBW)) - 64'd1);

  logic [GSW-1:0]  act  [NCH];
  logic [GSW-1:0]  pend [NCH];
  logic            pend_v;
  logic [GSW-1:0]  cnt;
  logic [PREW-1:0] pre;
  logic [LSBW-1:0] rep;
  logic            lsb_ph;

  logic [GSW-1:0]  cnt_top;
  logic [PREW-1:0] pre_last;
  logic [LSBW-1:0] rep_last;
  logic [NCH*GSW-1:0] act_flat;

  wire conv = (mode == 2'b11);

  always_comb begin
    if (conv)        cnt_top = depth16 ? FULL_W  : FULL_N;
    else if (lsb_ph) cnt_top = FULL_L;
    else             cnt_top = depth16 ? FULL_MW : FULL_MN;
    case (mode)
      2'b00:   begin pre_last = PREW'(0);  rep_last = {LSBW{1'b1}};      end
      2'b01:   begin pre_last = PREW'(3);  rep_last = {LSBW{1'b1}} >> 2; end
      2'b10:   begin pre_last = PREW'(15); rep_last = {LSBW{1'b1}} >> 4; end
      default: begin pre_last = '0;        rep_last = '0;                end
    endcase
  end

  wire pre_end  = conv | lsb_ph | (pre == pre_last);
  wire cnt_wrap = pre_end & (cnt == cnt_top);
  assign cycle_end = cnt_wrap & (conv | lsb_ph);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      pre    <= '0;
      rep    <= '0;
      lsb_ph <= 1'b0;
    end else if (conv || lsb_ph) begin
      pre <= '0;
      rep <= '0;
      cnt <= cnt_wrap ? '0 : cnt + 1'b1;
      if (cnt_wrap) lsb_ph <= 1'b0;
    end else begin
      pre <= pre_end ? '0 : pre + 1'b1;
      if (pre_end) cnt <= cnt_wrap ? '0 : cnt + 1'b1;
      if (cnt_wrap) begin
        rep <= (rep == rep_last) ? '0 : rep + 1'b1;
        if (rep == rep_last) lsb_ph <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v <= 1'b0;
      for (int i = 0; i < NCH; i++) begin
        act[i]  <= '0;
        pend[i] <= '0;
      end
    end else begin
      if (cycle_end && pend_v) begin
        pend_v <= 1'b0;
        for (int i = 0; i < NCH; i++) act[i] <= pend[i];
      end
      if (gs_load) begin
        if (sync_at_end) begin
          pend_v <= 1'b1;
          for (int i = 0; i < NCH; i++) pend[i] <= gs_data[i*GSW +: GSW];
        end else begin
          for (int i = 0; i < NCH; i++) act[i] <= gs_data[i*GSW +: GSW];
        end
      end
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    wire [GSW-1:0] v    = depth16 ? act[i] : (act[i] & FULL_N);
    wire [GSW-1:0] vmsb = v >> LSBW;
    wire [LSBW-1:0] vlsb = v[LSBW-1:0];
    assign act_flat[i*GSW +: GSW] = act[i];
    assign pwm_out[i] = conv   ? (cnt < v) :
                        lsb_ph ? (cnt[LSBW-1:0] < vlsb) :
                                 (cnt < vmsb);
  end
endmodule

// File: rtl/scrambled_gs_pwm_props.sv
`timescale 1ns/1ps
module scrambled_gs_pwm_props #(
  parameter int NCH  = 16,
  parameter int GSW  = 16,
  parameter int LSBW = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         mode,
  input logic               sync_at_end,
  input logic               gs_load,
  input logic [NCH*GSW-1:0] gs_data,
  input logic [NCH-1:0]     pwm_out,
  input logic               cycle_end,
  input logic [NCH*GSW-1:0] act_flat,
  input logic [GSW-1:0]     cnt,
  input logic [3:0]         pre,
  input logic [LSBW-1:0]    rep,
  input logic               lsb_ph
);
  for (genvar i = 0; i < NCH; i++) begin : g_dark
    assert_dark_when_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (act_flat[i*GSW +: GSW] == '0) |-> !pwm_out[i]);
  end

  assert_end_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_end |=> !cycle_end);

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_end |=> (cnt == '0 && pre == '0 && rep == '0 && !lsb_ph));

  assert_hold_until_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_at_end && !cycle_end) |=> $stable(act_flat));

  assert_immediate_apply_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_at_end && gs_load) |=> (act_flat == $past(gs_data)));

  assert_conv_single_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11) |-> !lsb_ph);
endmodule

bind scrambled_gs_pwm scrambled_gs_pwm_props #(.NCH(NCH), .GSW(GSW), .LSBW(LSBW)) props_i (
  .clk(clk), .rst_n(rst_n), .mode(mode), .sync_at_end(sync_at_end),
  .gs_load(gs_load), .gs_data(gs_data), .pwm_out(pwm_out), .cycle_end(cycle_end),
  .act_flat(act_flat), .cnt(cnt), .pre(pre), .rep(rep), .lsb_ph(lsb_ph)
);

// File: tb/scrambled_gs_pwm_test.sv
`timescale 1ns/1ps
module scrambled_gs_pwm_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         depth16 = 1'b0;
  logic [1:0]   mode = 2'b11;
  logic         sync_at_end = 1'b0;
  logic         gs_load = 1'b0;
  logic [255:0] gs_data = '0;
  logic [15:0]  pwm_out;
  logic         cycle_end;

  scrambled_gs_pwm uut (
    .clk(clk), .rst_n(rst_n), .depth16(depth16), .mode(mode),
    .sync_at_end(sync_at_end), .gs_load(gs_load), .gs_data(gs_data),
    .pwm_out(pwm_out), .cycle_end(cycle_end)
  );

  always #5 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  int act_m [16];
  int pend_m [16];
  bit pv;
  int t;
  string ho_tag;

  function automatic int eff(int v);
    return depth16 ? (v & 65535) : (v & 4095);
  endfunction

  function automatic int msbw();
    return depth16 ? 10 : 6;
  endfunction

  function automatic int cyc_len();
    if (mode == 2'b11) return depth16 ? 65536 : 4096;
    return (64 << msbw()) + 64;
  endfunction

  function automatic bit exp_on(int v, int pos);
    int vv = eff(v);
    int span;
    int step;
    if (mode == 2'b11) return pos < vv;
    span = 64 << msbw();
    if (pos < span) begin
      step = (pos / (1 << (2 * int'(mode)))) % (1 << msbw());
      return step < (vv >> 6);
    end
    return (pos - span) < (vv & 63);
  endfunction

  function automatic string mode_tag();
    if (!rst_n) return "R1";
    if (mode == 2'b11) return "R2";
    if (depth16) return "R6";
    case (mode)
      2'b00:   return "R3";
      2'b01:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s t=%0d actual=%0h expected=%0h", tag, t, act, exp);
    end
  endtask

  task automatic model_update();
    ho_tag = "";
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin act_m[i] = 0; pend_m[i] = 0; end
      pv = 0;
      t = 0;
      return;
    end
    if (t == cyc_len() - 1 && pv) begin
      for (int i = 0; i < 16; i++) act_m[i] = pend_m[i];
      pv = 0;
      ho_tag = "R9";
    end
    if (gs_load) begin
      for (int i = 0; i < 16; i++) begin
        if (sync_at_end) pend_m[i] = int'(gs_data[i*16 +: 16]);
        else act_m[i] = int'(gs_data[i*16 +: 16]);
      end
      if (sync_at_end) pv = 1;
      else ho_tag = "R10";
    end
    t = (t == cyc_len() - 1) ? 0 : t + 1;
  endtask

  task automatic check_all();
    string tag;
    for (int i = 0; i < 16; i++) begin
      if (eff(act_m[i]) == 0 && rst_n) tag = "R7";
      else if (ho_tag != "") tag = ho_tag;
      else tag = mode_tag();
      check(tag, int'(pwm_out[i]), int'(rst_n && exp_on(act_m[i], t)));
    end
    check(rst_n ? "R8" : "R1", int'(cycle_end), int'(rst_n && t == cyc_len() - 1));
  endtask

  task automatic tick();
    @(posedge clk);
    model_update();
    @(negedge clk);
    check_all();
  endtask

  function automatic logic [255:0] rand_word();
    logic [255:0] w;
    int k;
    for (int i = 0; i < 16; i++) begin
      k = int'($urandom_range(0, 3));
      if (k == 0) w[i*16 +: 16] = 16'h0000;
      else if (k == 1) w[i*16 +: 16] = depth16 ? 16'hFFFF : {4'($urandom), 12'hFFF};
      else if (!depth16 || mode != 2'b11) w[i*16 +: 16] = 16'($urandom);
      else w[i*16 +: 16] = 16'($urandom_range(0, 3000));
    end
    return w;
  endfunction

  task automatic load(logic [255:0] w);
    gs_data = w;
    gs_load = 1'b1;
    tick();
    gs_load = 1'b0;
  endtask

  task automatic configure(bit d, logic [1:0] m, bit s);
    rst_n = 1'b0;
    depth16 = d;
    mode = m;
    sync_at_end = s;
    for (int k = 0; k < 3; k++) tick();
    rst_n = 1'b1;
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) begin
      if ($urandom_range(0, 1499) == 0) load(rand_word());
      else tick();
    end
  endtask

  initial begin
    logic [255:0] w;
    void'($urandom(32'h5EED));
    ho_tag = "";
    // R1: reset state sampled while rst_n is held
    configure(1'b0, 2'b11, 1'b0);

    // R11: channel i gets 256*i, so at position 1000 channels 4..15 are on
    for (int i = 0; i < 16; i++) w[i*16 +: 16] = 16'(256 * i);
    load(w);
    while (t != 1000) tick();
    check("R11", int'(pwm_out), 16'hFFF0);
    run(8200);

    configure(1'b0, 2'b00, 1'b1);
    load(rand_word());
    run(8400);

    configure(1'b0, 2'b01, 1'b0);
    load(rand_word());
    run(8400);

    configure(1'b0, 2'b10, 1'b1);
    load(rand_word());
    run(8400);

    configure(1'b1, 2'b01, 1'b1);
    load(rand_word());
    run(65700);

    configure(1'b1, 2'b11, 1'b0);
    load(rand_word());
    run(3000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1900000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule